// File: doc/BRIEF.md
# Audio Group Delay with Low-Latency Bypass Mix

This block holds back four audio channels by a programmable number of sample periods, so that a fifth channel passes ahead of them in time. The fifth channel is a power-supply tracking signal. It goes straight through with only the output register as latency, so the supply can rise before the loud audio that needs it arrives. A delay of 24 samples at 48 kHz is 500 microseconds.

A single low-latency stream is added to every delayed audio channel after the delay stage, so that stream is never held back. Each sum saturates to the 24-bit two's-complement limits.

All inputs are taken on a one-cycle sample strobe, and the results appear one clock later. Each channel has a 32-entry circular buffer, and all channels share one write pointer. The delay setting is sampled on every strobe, so a change applies to the sample presented with it.

Top module: `audio_gdly`

## Requirements
- R1: While reset is asserted, `out_valid`, every `aud_out` lane and `trk_out` are zero.
- R2: `out_valid` is high for exactly the one clock after each clock in which `smp_valid` is high, and is low at all other times.
- R3: The clock after a strobe, `trk_out` equals the `trk_in` presented with that strobe, with no added sample delay.
- R4: For a strobe with effective delay D between 1 and 24, audio lane k (bits 24k+23 down to 24k) shows the saturated sum of two values: the lane-k sample presented D strobes earlier, and the `lowlat_in` presented with the current strobe.
- R5: A delay setting of 0 gives a direct pass-through: the output is the current lane sample plus the current `lowlat_in`.
- R6: A delayed sample that would come from a strobe before the first strobe since reset reads as zero, so the output is `lowlat_in` alone.
- R7: When a sum exceeds the 24-bit signed range, the output is clamped to +8388607 or -8388608.
- R8: A `delay_cfg` value above 24 behaves exactly as 24.
- R9: The setting presented with a strobe governs that strobe's output. Buffer contents are kept across setting changes, so a new setting reads the sample that lies that many strobes back.
- R10: Between strobes, `aud_out` and `trk_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle sample strobe |
| delay_cfg | input | 5 | Delay in samples, 0 to 31 (values above 24 are clamped) |
| aud_in | input | 96 | Four 24-bit signed audio samples, lane k at bits 24k+23:24k |
| trk_in | input | 24 | Tracking channel sample |
| lowlat_in | input | 24 | Low-latency sample added to every audio lane |
| out_valid | output | 1 | Output strobe, one clock after `smp_valid` |
| aud_out | output | 96 | Delayed, mixed, saturated audio lanes |
| trk_out | output | 24 | Undelayed tracking sample |

## Verification
The bench covers the opening strobes after reset with a nonzero delay. A design that read stale buffer contents would emit junk there instead of the low-latency value alone. It drives a zero setting, which exposes a read pointer one entry off as a one-sample lag. It also drives settings above 24 and a setting that alternates between strobes, where a missing clamp or a lagging setting register shows as the wrong past sample. Near-full-scale inputs mixed with large low-latency values check that overflow clamps and does not wrap to the opposite sign.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam int SMP_W = 24;
  typedef logic signed [SMP_W-1:0] smp_t;

  // Sum of two samples clamped to the signed range of smp_t.
  function automatic smp_t sat_add(smp_t a, smp_t b);
    logic signed [SMP_W:0] s;
    s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    if (s[SMP_W] != s[SMP_W-1])
      return s[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
    return s[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/gd_wrptr.sv
module gd_wrptr #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] wr_ptr,
  output logic [AW:0]   fill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (adv) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fill != (AW+1)'(DEPTH)) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/gd_rdsel.sv
module gd_rdsel #(
  parameter int DEPTH   = 32,
  parameter int MAX_DLY = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0] cfg,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW:0]   fill,
  output logic [AW-1:0] rd_ptr,
  output logic          bypass,
  output logic          blank
);
  logic [AW-1:0] dly;

  always_comb begin
    dly    = (cfg > AW'(MAX_DLY)) ? AW'(MAX_DLY) : cfg;
    rd_ptr = wr_ptr - dly;
    bypass = (dly == '0);
    blank  = ({1'b0, dly} > fill);
  end
endmodule

// File: rtl/gd_lane.sv
module gd_lane
  import gd_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic          bypass,
  input  logic          blank,
  input  smp_t          din,
  input  smp_t          mix,
  output smp_t          dout
);
  smp_t mem [DEPTH];
  smp_t tap;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_comb begin
    if (bypass)     tap = din;
    else if (blank) tap = '0;
    else            tap = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= '0;
    else if (wr_en) dout <= sat_add(tap, mix);
  end
endmodule

// File: rtl/audio_gdly.sv
module audio_gdly
  import gd_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DEPTH   = 32,
  parameter int MAX_DLY = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [AW-1:0]      delay_cfg,
  input  logic [NCH*SMP_W-1:0] aud_in,
  input  logic [SMP_W-1:0]   trk_in,
  input  logic [SMP_W-1:0]   lowlat_in,
  output logic               out_valid,
  output logic [NCH*SMP_W-1:0] aud_out,
  output logic [SMP_W-1:0]   trk_out
);
  logic [AW-1:0] wr_ptr;
  logic [AW:0]   fill;
  logic [AW-1:0] rd_ptr;
  logic          bypass;
  logic          blank;

  gd_wrptr #(.DEPTH(DEPTH)) u_wp (
    .clk(clk), .rst_n(rst_n), .adv(smp_valid), .wr_ptr(wr_ptr), .fill(fill)
  );

  gd_rdsel #(.DEPTH(DEPTH), .MAX_DLY(MAX_DLY)) u_rs (
    .cfg(delay_cfg), .wr_ptr(wr_ptr), .fill(fill),
    .rd_ptr(rd_ptr), .bypass(bypass), .blank(blank)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    smp_t lane_q;
    gd_lane #(.DEPTH(DEPTH)) u_lane (
      .clk(clk), .rst_n(rst_n), .wr_en(smp_valid),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .bypass(bypass), .blank(blank),
      .din(aud_in[k*SMP_W +: SMP_W]), .mix(lowlat_in), .dout(lane_q)
    );
    assign aud_out[k*SMP_W +: SMP_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      trk_out   <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) trk_out <= trk_in;
    end
  end
endmodule

// File: rtl/gd_chk.sv
module gd_chk #(
  parameter int NCH = 4,
  parameter int SW  = 24,
  parameter int AW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [AW-1:0]     delay_cfg,
  input logic [NCH*SW-1:0] aud_in,
  input logic [SW-1:0]     trk_in,
  input logic [SW-1:0]     lowlat_in,
  input logic              out_valid,
  input logic [NCH*SW-1:0] aud_out,
  input logic [SW-1:0]     trk_out
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid); // R2
  AST_VALID_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid); // R2
  AST_TRK_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> trk_out == $past(trk_in)); // R3
  AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && delay_cfg == '0 && lowlat_in == '0) |=> aud_out == $past(aud_in)); // R5
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(aud_out) && $stable(trk_out))); // R10
endmodule

bind audio_gdly gd_chk #(.NCH(NCH), .SW(gd_pkg::SMP_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .delay_cfg(delay_cfg),
  .aud_in(aud_in), .trk_in(trk_in), .lowlat_in(lowlat_in),
  .out_valid(out_valid), .aud_out(aud_out), .trk_out(trk_out)
);

// File: tb/sim_audio_gdly.sv
module sim_audio_gdly;
  localparam int NCH = 4;
  localparam int SW  = 24;
  localparam int MAXP = 8388607;
  localparam int MINN = -8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [4:0] delay_cfg = '0;
  logic [NCH*SW-1:0] aud_in = '0;
  logic [SW-1:0] trk_in = '0;
  logic [SW-1:0] lowlat_in = '0;
  logic out_valid;
  logic [NCH*SW-1:0] aud_out;
  logic [SW-1:0] trk_out;

  always #5 clk = ~clk;

  audio_gdly u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .delay_cfg(delay_cfg),
    .aud_in(aud_in), .trk_in(trk_in), .lowlat_in(lowlat_in),
    .out_valid(out_valid), .aud_out(aud_out), .trk_out(trk_out)
  );

  int vectors = 0;
  int miscompares = 0;
  int hist [NCH][$];
  int exp_aud [NCH];
  int exp_trk = 0;
  bit exp_valid = 1'b0;
  string tag_aud = "R1";
  string tag_trk = "R1";

  function automatic int clamp24(int v);
    if (v > MAXP) return MAXP;
    if (v < MINN) return MINN;
    return v;
  endfunction

  function automatic int pick(bit big);
    int m;
    if (big) begin
      m = 8000000 + int'($urandom % 388608);
      return ($urandom % 2) ? m : -m;
    end
    return int'($urandom % 2097152) - 1048576;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2", int'(out_valid), int'(exp_valid), "out_valid");
    check(tag_trk, int'($signed(trk_out)), exp_trk, "trk_out");
    for (int c = 0; c < NCH; c++)
      check(tag_aud, int'($signed(aud_out[c*SW +: SW])), exp_aud[c], $sformatf("aud_out[%0d]", c));
  endtask

  // Compare what the last edge produced, then drive the next cycle.
  task automatic step(bit v, int cfg, bit big, bit bigll, string tag);
    int d, ll, tk, s;
    int smp [NCH];
    compare_all();
    smp_valid = v;
    if (!v) begin
      exp_valid = 1'b0;
      tag_aud = "R10"; tag_trk = "R10";
    end else begin
      d = (cfg > 24) ? 24 : cfg;
      ll = bigll ? pick(1'b1) : pick(1'b0) / 8;
      tk = pick(1'b0);
      delay_cfg = 5'(cfg);
      lowlat_in = SW'(ll);
      trk_in = SW'(tk);
      for (int c = 0; c < NCH; c++) begin
        smp[c] = pick(big);
        aud_in[c*SW +: SW] = SW'(smp[c]);
        if (d == 0) s = smp[c];
        else if (d > hist[c].size()) s = 0;
        else s = hist[c][d-1];
        exp_aud[c] = clamp24(s + ll);
        hist[c].push_front(smp[c]);
        if (hist[c].size() > 32) void'(hist[c].pop_back());
      end
      tag_aud = (d > hist[0].size() - 1 && d != 0) ? "R6" : tag;
      exp_trk = tk;
      exp_valid = 1'b1;
      tag_trk = "R3";
    end
    @(negedge clk);
  endtask

  task automatic run(int n, int cfg, bit rnd_cfg, bit big, bit bigll, string tag);
    int cf;
    for (int i = 0; i < n; i++) begin
      cf = rnd_cfg ? int'($urandom % 24) + 1 : cfg;
      step(1'b1, cf, big, bigll, tag);
      for (int g = int'($urandom % 3); g > 0; g--) step(1'b0, 0, 1'b0, 1'b0, tag);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) exp_aud[c] = 0;
    @(negedge clk);
    aud_in = '1; trk_in = '1; lowlat_in = '1; smp_valid = 1'b1;
    @(negedge clk);
    // R1: outputs held at zero while reset is low, even with a strobe
    check("R1", int'(out_valid), 0, "out_valid");
    check("R1", int'(trk_out), 0, "trk_out");
    check("R1", int'(aud_out != '0), 0, "aud_out nonzero");
    smp_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run(14, 10, 1'b0, 1'b0, 1'b0, "R4");   // R6 on the opening strobes
    run(10, 0, 1'b0, 1'b0, 1'b0, "R5");    // R5 pass-through
    run(40, 24, 1'b0, 1'b0, 1'b0, "R4");   // R4 full delay
    run(20, 0, 1'b1, 1'b0, 1'b0, "R4");    // R4 assorted delays
    for (int i = 0; i < 8; i++) run(1, 25 + i % 7, 1'b0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 12; i++) run(1, (i % 2) ? 17 : 3, 1'b0, 1'b0, 1'b0, "R9");
    run(12, 0, 1'b0, 1'b1, 1'b1, "R7");    // R7 saturation, direct
    run(12, 5, 1'b0, 1'b1, 1'b1, "R7");    // R7 saturation, delayed
    step(1'b0, 0, 1'b0, 1'b0, "R10");
    step(1'b0, 0, 1'b0, 1'b0, "R10");
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule